// File: doc/BRIEF.md
# Packed-Decimal Adder/Subtractor

This block is a purely combinational decimal arithmetic unit. It takes two unsigned packed-BCD operands of `DIGITS` decimal digits, four bits per digit, and either adds or subtracts them, depending on a single mode input.

In add mode it produces the packed-BCD sum and a decimal carry out of the top digit. In subtract mode it produces the magnitude of the difference, in packed BCD, together with a sign flag.

Every digit position is a slice. Each slice first does a 4-bit binary addition and then applies a decimal correction. The slices ripple their decimal carries upward.

Subtraction works in these steps:

1. Each subtrahend digit is replaced by its nine's complement. That complement is formed by inverting the digit and adding 1010.
2. The complemented subtrahend is added to the minuend.
3. If the top slice carries, the result is positive, and the carry is fed back into the lowest digit by a second ripple pass.
4. If the top slice does not carry, the digits hold the nine's complement of the magnitude, and they are complemented once more.

A separate flag reports any operand digit outside the decimal range.

Top module: `bcd_addsub`

## Requirements
- R1: Whenever every operand digit is in the range 0 to 9, every 4-bit field of `result` is in the range 0000 to 1001.
- R2: With `sub_mode`=0, the decimal value of `carry_out` times 10^DIGITS plus the value of `result` equals A + B.
- R3: A digit slice corrects its binary sum by adding 0110 and emits a decimal carry whenever that sum, including the incoming carry, exceeds 9. For example 8+8 gives digit 6 with carry 1, and 9+9 gives digit 8 with carry 1.
- R4: The nine's complement of each digit is 9 minus the digit. For example, 99 − 28 gives 71 and 999 − 562 gives 437.
- R5: With `sub_mode`=1 and A ≥ B, `negative`=0 and `result` equals A − B. This uses the end-around carry from the top slice.
- R6: With `sub_mode`=1 and A < B, `negative`=1 and `result` equals B − A. For example, 86 − 99 gives magnitude 13 with `negative`=1.
- R7: With `sub_mode`=1 and A = B, `result` is all zeros and `negative`=0.
- R8: `carry_out` is 0 in subtract mode, and `negative` is 0 in add mode.
- R9: `input_invalid` is 1 exactly when at least one 4-bit field of `op_a` or `op_b` is greater than 1001. For invalid operands, the other outputs are a fixed function of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4*DIGITS | Minuend / first addend, packed BCD, digit 0 in bits [3:0] |
| op_b | input | 4*DIGITS | Subtrahend / second addend, packed BCD |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | 4*DIGITS | Packed-BCD sum, or magnitude of the difference |
| carry_out | output | 1 | Decimal carry out of the top digit in add mode |
| negative | output | 1 | Sign of the difference in subtract mode (1 = negative) |
| input_invalid | output | 1 | Some operand digit is above 9 |

## Verification
The bound checker watches, on every input change, four things:
- the decimal range of every output digit;
- the mutual exclusion between `carry_out` and `negative` across the two modes;
- the positive sign of a zero difference, and the invalid-digit flag;
- the absence of any overflow from the end-around pass.

Only the bench's sweeps can show that the numeric values themselves are right. That covers sums with carries through every slice, the worked complements 71 and 437, and negative differences recomplemented to their magnitude.

// File: rtl/bcd_calc_pkg.sv
package bcd_calc_pkg;

  typedef struct packed {
    logic       carry;
    logic [3:0] digit;
  } slice_res_t;

  // 9 - d, formed as inverted digit plus ten, overflow dropped
  function automatic logic [3:0] nine_comp(input logic [3:0] d);
    return (~d) + 4'b1010;
  endfunction

  // binary add of one digit pair, then decimal correction
  function automatic slice_res_t dec_add(input logic [3:0] a,
                                         input logic [3:0] b,
                                         input logic       ci);
    logic [4:0] bin;
    logic       fix;
    slice_res_t r;
    bin     = {1'b0, a} + {1'b0, b} + {4'b0000, ci};
    fix     = bin[4] | (bin[3] & bin[2]) | (bin[3] & bin[1]);
    r.digit = bin[3:0] + (fix ? 4'b0110 : 4'b0000);
    r.carry = fix;
    return r;
  endfunction

  function automatic logic digit_bad(input logic [3:0] d);
    return d[3] & (d[2] | d[1]);
  endfunction

endpackage

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
  import bcd_calc_pkg::*;
(
  input  logic [3:0] a_dig,
  input  logic [3:0] b_dig,
  input  logic       c_in,
  output logic [3:0] s_dig,
  output logic       c_out
);
  slice_res_t res;

  always_comb begin
    res   = dec_add(a_dig, b_dig, c_in);
    s_dig = res.digit;
    c_out = res.carry;
  end
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [DIGITS:0] chain;

  assign chain[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_slice
    bcd_digit_slice u_slice (
      .a_dig (x[4*g +: 4]),
      .b_dig (y[4*g +: 4]),
      .c_in  (chain[g]),
      .s_dig (sum[4*g +: 4]),
      .c_out (chain[g+1])
    );
  end

  assign cout = chain[DIGITS];
endmodule

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
  import bcd_calc_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign dout[4*g +: 4] = nine_comp(din[4*g +: 4]);
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_calc_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_mode,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         negative,
  output logic         input_invalid
);
  logic [W-1:0] b_comp;
  logic [W-1:0] addend;
  logic [W-1:0] raw_sum;
  logic [W-1:0] adj_sum;
  logic [W-1:0] neg_form;
  logic         msd_carry;
  logic         end_around;
  logic         wrap_carry;
  logic         recomplement;
  logic [W-1:0] magnitude;

  // subtrahend in nine's complement form
  bcd_nines_comp #(.DIGITS(DIGITS)) u_bcomp (.din(op_b), .dout(b_comp));

  assign addend = sub_mode ? b_comp : op_b;

  // first pass: A + B or A + comp(B)
  bcd_ripple_adder #(.DIGITS(DIGITS)) u_pass1 (
    .x(op_a), .y(addend), .cin(1'b0), .sum(raw_sum), .cout(msd_carry)
  );

  assign end_around   = sub_mode & msd_carry;
  assign recomplement = sub_mode & ~msd_carry;

  // second pass: fold the end-around carry into digit 0
  bcd_ripple_adder #(.DIGITS(DIGITS)) u_pass2 (
    .x(raw_sum), .y({W{1'b0}}), .cin(end_around), .sum(adj_sum), .cout(wrap_carry)
  );

  // negative difference: complement again to get the magnitude
  bcd_nines_comp #(.DIGITS(DIGITS)) u_rcomp (.din(raw_sum), .dout(neg_form));

  always_comb begin
    if (recomplement)    magnitude = neg_form;
    else if (end_around) magnitude = adj_sum;
    else                 magnitude = raw_sum;
  end

  always_comb begin
    input_invalid = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      input_invalid = input_invalid | digit_bad(op_a[4*i +: 4])
                                    | digit_bad(op_b[4*i +: 4]);
    end
  end

  assign result    = magnitude;
  assign carry_out = ~sub_mode & msd_carry;
  assign negative  = recomplement & (|magnitude);
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sub_mode,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         negative,
  input logic         input_invalid,
  input logic         msd_carry,
  input logic         wrap_carry
);
  logic any_bad_in;
  logic any_bad_out;

  always_comb begin
    any_bad_in  = 1'b0;
    any_bad_out = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      if (op_a[4*i +: 4] > 4'd9 || op_b[4*i +: 4] > 4'd9) any_bad_in = 1'b1;
      if (result[4*i +: 4] > 4'd9) any_bad_out = 1'b1;
    end
  end

  always_comb begin
    AST_DIGITS_DECIMAL: assert (any_bad_in || !any_bad_out);                    // R1
    AST_ADD_NO_SIGN:    assert (sub_mode || !negative);                          // R8
    AST_SUB_NO_CARRY:   assert (!sub_mode || !carry_out);                        // R8
    AST_ZERO_POSITIVE:  assert (any_bad_in || result != '0 || !negative);        // R7
    AST_INVALID_FLAG:   assert (input_invalid == any_bad_in);                    // R9
    AST_NO_WRAP:        assert (any_bad_in || !(sub_mode && msd_carry) || !wrap_carry); // R5
    AST_POS_ON_CARRY:   assert (any_bad_in || !(sub_mode && msd_carry) || !negative);   // R5
  end
endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .op_a          (op_a),
  .op_b          (op_b),
  .sub_mode      (sub_mode),
  .result        (result),
  .carry_out     (carry_out),
  .negative      (negative),
  .input_invalid (input_invalid),
  .msd_carry     (msd_carry),
  .wrap_carry    (wrap_carry)
);

// File: tb/tb_bcd_addsub.sv
`timescale 1ns/1ps
module tb_bcd_addsub;
  localparam int DIGITS = 3;
  localparam int W = 4 * DIGITS;
  localparam int MOD = 1000;

  logic         clk = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         negative;
  logic         input_invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_addsub #(.DIGITS(DIGITS)) dut (
    .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .result(result), .carry_out(carry_out),
    .negative(negative), .input_invalid(input_invalid)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_raw(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; sub_mode = s;
    @(negedge clk);
  endtask

  // apply decimal operands and compare every output against arithmetic
  task automatic run_vec(input int a, input int b, input logic s, input string tag);
    int  exp_val;
    bit  exp_c, exp_n;
    int  bad;
    drive_raw(to_bcd(a), to_bcd(b), s);
    if (!s) begin
      exp_c   = (a + b) >= MOD;
      exp_val = (a + b) % MOD;
      exp_n   = 1'b0;
    end else begin
      exp_c   = 1'b0;
      exp_n   = a < b;
      exp_val = exp_n ? b - a : a - b;
    end
    check(tag, "result",        result,        to_bcd(exp_val));
    check(tag, "carry_out",     carry_out,     exp_c);
    check(tag, "negative",      negative,      exp_n);
    check("R9", "input_invalid", input_invalid, 0);
    bad = 0;
    for (int i = 0; i < DIGITS; i++) if (result[4*i +: 4] > 4'd9) bad++;
    check("R1", "digits above nine", bad, 0);
  endtask

  initial begin
    // idle state with zero operands
    run_vec(0, 0, 1'b0, "R2");
    // slice corrections
    run_vec(8, 8, 1'b0, "R3");
    run_vec(9, 9, 1'b0, "R3");
    run_vec(5, 5, 1'b0, "R3");
    run_vec(99, 1, 1'b0, "R3");
    run_vec(999, 1, 1'b0, "R2");
    run_vec(999, 999, 1'b0, "R2");
    // worked complements
    run_vec(99, 28, 1'b1, "R4");
    run_vec(999, 562, 1'b1, "R4");
    // negative difference and zero
    run_vec(86, 99, 1'b1, "R6");
    run_vec(0, 999, 1'b1, "R6");
    run_vec(555, 555, 1'b1, "R7");
    run_vec(0, 0, 1'b1, "R7");
    run_vec(1, 0, 1'b1, "R5");
    check("R8", "sub carry_out", carry_out, 0);
    // invalid digit flag
    drive_raw(12'h0A0, 12'h000, 1'b0);
    check("R9", "flag A digit1", input_invalid, 1);
    drive_raw(12'h000, 12'h00F, 1'b1);
    check("R9", "flag B digit0", input_invalid, 1);
    drive_raw(12'hC99, 12'h999, 1'b1);
    check("R9", "flag A digit2", input_invalid, 1);
    drive_raw(12'h999, 12'h999, 1'b0);
    check("R9", "flag all nines", input_invalid, 0);
    // sweeps: every minuend against a spread of second operands
    for (int k = 0; k < 45; k++) begin
      int b;
      case (k)
        0: b = 0;
        1: b = 999;
        2: b = 1;
        3: b = 562;
        4: b = 28;
        default: b = (k * 97 + 13) % MOD;
      endcase
      for (int a = 0; a < MOD; a++) begin
        run_vec(a, b, 1'b0, "R2");
        if (a >= b) run_vec(a, b, 1'b1, "R5");
        else        run_vec(a, b, 1'b1, "R6");
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule